// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement State

This block holds the replacement history for every set of a set-associative cache whose associativity is a power of two. Each set owns a binary decision tree of one bit per internal node. When the cache touches a way, it presents the set and the way on the update port, and the tree bits on that way's root-to-leaf path are rewritten to point away from it. When the cache needs a line to replace, it presents a set index on the query port and gets back a victim way at once. The victim is found by following the tree bits from the root down to a leaf.

The tree is stored in heap order: node `n` has children `2n+1` and `2n+2`. Bit value 0 steers the walk left and 1 steers it right. A single clear input wipes every set back to its initial state. Tag compare, line status and data arrays live elsewhere in the cache.

Top module: `plru_top`

## Requirements
- R1: After reset every tree bit of every set is 0, so a query of any set returns way 0.
- R2: An update for way w in set s rewrites that set's path nodes. For W ways the first bottom-row node is (W-1)/2. The leaf node (w/2)+(W-1)/2 takes the inverse of bit 0 of w. Climbing from node i to its parent (i-1)/2, the parent takes i mod 2, up to and including the root.
- R3: Tree bits of set s that are not on the updated path keep their values.
- R4: A query walks from the root, going to child 2n+1 on a 0 bit and to 2n+2 on a 1 bit, until it reaches a bottom-row node i. The victim is 2*(i-(W-1)/2), plus 1 when that node's bit is 1.
- R5: An update changes no set other than the one it addresses.
- R6: The victim output depends combinationally on the query set. An update takes effect at the next rising clock edge, so a query of the same set in the same cycle sees the state from before the update.
- R7: A clear returns all tree bits of all sets to 0 at the next edge. When clear and an update arrive in the same cycle, the clear wins and the update is dropped.
- R8: With a single way, updates have no effect and the victim is always way 0.
- R9: With two or more ways, a query of a set in the cycle after an update to that set never returns the way just updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearAll | input | 1 | Zero the trees of all sets at the next edge |
| updValid | input | 1 | Update strobe for the touched way |
| updSet | input | SET_W | Set index of the update |
| updWay | input | WAY_W | Way that was just used |
| querySet | input | SET_W | Set index of the victim query |
| victimWay | output | WAY_W | Way chosen for replacement in the queried set |

## Verification
The assertions assume that `updWay` is always below the way count and that both set indices are below the set count. Under those conditions the path nodes of every update are distinct and lie inside one set's tree. The random stimulus draws indices only inside those ranges. It points the query at the updated set about half the time, so the same-cycle and next-cycle properties are exercised often. Clear pulses are kept rare but are sometimes placed together with an update, which is the case that the priority rule and the post-clear property depend on.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // Strobes from control to the tree storage.
  typedef struct packed {
    logic clr;  // zero every set
    logic wr;   // masked write into one set
  } plruStrobe_t;

endpackage

// File: rtl/plru_ctrl.sv
module plru_ctrl
  import plru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int SET_W    = 4,
  parameter int WAY_W    = 2,
  parameter int TREE_W   = 3,
  parameter int LEVELS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearAll,
  input  logic              updValid,
  input  logic [SET_W-1:0]  updSet,
  input  logic [WAY_W-1:0]  updWay,
  output plruStrobe_t       strobe,
  output logic [SET_W-1:0]  wrSet,
  output logic [TREE_W-1:0] wrMask,
  output logic [TREE_W-1:0] wrBits
);

  // Path nodes of the touched way. At depth d the node index is
  // (2^d - 1) + (way >> (LEVELS-d)). It points away from the way,
  // which gives the inverse of way bit LEVELS-1-d.
  always_comb begin
    int nodeIdx;
    wrMask = '0;
    wrBits = '0;
    for (int d = 0; d < LEVELS; d++) begin
      nodeIdx = ((1 << d) - 1) + int'(updWay >> (LEVELS - d));
      wrMask[nodeIdx] = 1'b1;
      wrBits[nodeIdx] = ~updWay[LEVELS-1-d];
    end
  end

  assign wrSet      = updSet;
  assign strobe.clr = clearAll;
  // Clear has priority over an update (R7). A single-way tree never changes (R8).
  assign strobe.wr  = updValid && !clearAll && (NUM_WAYS > 1);

  // R2: each write touches exactly one node per tree level.
  assert_path_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wr |-> ($countones(wrMask) == LEVELS))
    else $error("path mask width wrong");

  // R3: no value bit is set outside the written path.
  assert_bits_in_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wr |-> ((wrBits & ~wrMask) == '0))
    else $error("value bit outside path");

endmodule

// File: rtl/plru_dp.sv
module plru_dp
  import plru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  parameter int SET_W    = 4,
  parameter int WAY_W    = 2,
  parameter int TREE_W   = 3,
  parameter int LEVELS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  plruStrobe_t       strobe,
  input  logic [SET_W-1:0]  wrSet,
  input  logic [TREE_W-1:0] wrMask,
  input  logic [TREE_W-1:0] wrBits,
  input  logic [SET_W-1:0]  querySet,
  output logic [WAY_W-1:0]  victimWay
);

  generate
    if (NUM_WAYS == 1) begin : g_single
      // R8: nothing to remember, the only way is the victim.
      assign victimWay = '0;
    end else begin : g_tree
      logic [NUM_SETS-1:0][TREE_W-1:0] treeQ;

      always_ff @(posedge clk) begin
        if (!rstN || strobe.clr) begin
          treeQ <= '0;
        end else if (strobe.wr) begin
          treeQ[wrSet] <= (treeQ[wrSet] & ~wrMask) | (wrBits & wrMask);
        end
      end

      // Victim walk: the bit at depth d selects the child and also
      // forms way bit LEVELS-1-d (R4).
      always_comb begin
        logic [TREE_W-1:0] row;
        int node;
        row       = treeQ[querySet];
        node      = 0;
        victimWay = '0;
        for (int d = 0; d < LEVELS; d++) begin
          victimWay[LEVELS-1-d] = row[node];
          node = 2 * node + 1 + int'(row[node]);
        end
      end

      // R3 and R5: without a write or a clear, no tree bit moves.
      assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
        !(strobe.wr || strobe.clr) |=> $stable(treeQ))
        else $error("tree changed without a write");
    end
  endgenerate

endmodule

// File: rtl/plru_top.sv
module plru_top
  import plru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearAll,
  input  logic             updValid,
  input  logic [SET_W-1:0] updSet,
  input  logic [WAY_W-1:0] updWay,
  input  logic [SET_W-1:0] querySet,
  output logic [WAY_W-1:0] victimWay
);

  localparam int LEVELS = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 0;
  localparam int TREE_W = (NUM_WAYS > 1) ? NUM_WAYS - 1 : 1;

  plruStrobe_t       strobe;
  logic [SET_W-1:0]  wrSet;
  logic [TREE_W-1:0] wrMask;
  logic [TREE_W-1:0] wrBits;

  plru_ctrl #(
    .NUM_WAYS(NUM_WAYS), .SET_W(SET_W), .WAY_W(WAY_W),
    .TREE_W(TREE_W), .LEVELS(LEVELS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .clearAll(clearAll), .updValid(updValid),
    .updSet(updSet), .updWay(updWay), .strobe(strobe), .wrSet(wrSet),
    .wrMask(wrMask), .wrBits(wrBits)
  );

  plru_dp #(
    .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .SET_W(SET_W), .WAY_W(WAY_W),
    .TREE_W(TREE_W), .LEVELS(LEVELS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrSet(wrSet), .wrMask(wrMask),
    .wrBits(wrBits), .querySet(querySet), .victimWay(victimWay)
  );

  // R7: after a clear every set walks straight to way 0.
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (victimWay == '0))
    else $error("victim not zero after clear");

  generate
    if (NUM_WAYS == 1) begin : g_chk_single
      // R8
      assert_single_way_R8: assert property (@(posedge clk) disable iff (!rstN)
        victimWay == '0)
        else $error("single way victim not zero");
    end else begin : g_chk_multi
      // R9: the just-used way is never the next victim of its set.
      assert_not_recent_R9: assert property (@(posedge clk) disable iff (!rstN)
        (updValid && !clearAll) |=>
          ((querySet != $past(updSet)) || (victimWay != $past(updWay))))
        else $error("recently used way chosen as victim");
    end
  endgenerate

endmodule

// File: tb/tb_plru_top.sv
`timescale 1ns/1ps
module tb_plru_top;

  localparam int NW     = 4;
  localparam int NS     = 16;
  localparam int BOTTOM = (NW - 1) / 2;
  localparam real HALF  = 4.0;  // 125 MHz

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clearAll = 1'b0;
  logic       updValid = 1'b0;
  logic [3:0] updSet = '0;
  logic [1:0] updWay = '0;
  logic [3:0] querySet = '0;
  logic [1:0] victimWay;
  logic [0:0] victim1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit mdl [NS][NW-1];

  always #(HALF) clk = ~clk;

  plru_top #(.NUM_WAYS(NW), .NUM_SETS(NS)) dut (
    .clk(clk), .rstN(rstN), .clearAll(clearAll), .updValid(updValid),
    .updSet(updSet), .updWay(updWay), .querySet(querySet), .victimWay(victimWay)
  );

  // Single-way variant, driven with the same control (R8).
  plru_top #(.NUM_WAYS(1), .NUM_SETS(NS)) dut1 (
    .clk(clk), .rstN(rstN), .clearAll(clearAll), .updValid(updValid),
    .updSet(updSet), .updWay(1'b0), .querySet(querySet), .victimWay(victim1)
  );

  function automatic int modelVictim(int s);
    int i = 0;
    while (i < BOTTOM) i = mdl[s][i] ? 2 * i + 2 : 2 * i + 1;
    return 2 * (i - BOTTOM) + int'(mdl[s][i]);
  endfunction

  function automatic void modelUpdate(int s, int w);
    int i = w / 2 + BOTTOM;
    mdl[s][i] = ((w % 2) == 0);
    while (i > 0) begin
      int p = (i - 1) / 2;
      mdl[s][p] = (i % 2) == 1;
      i = p;
    end
  endfunction

  function automatic void modelClear();
    for (int s = 0; s < NS; s++)
      for (int n = 0; n < NW - 1; n++) mdl[s][n] = 1'b0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive after the falling edge, check the query against the
  // pre-edge model (R6), then commit the edge to the model.
  task automatic step(bit clr, bit uv, int us, int uw, int qs, string req);
    clearAll = clr; updValid = uv;
    updSet = 4'(us); updWay = 2'(uw); querySet = 4'(qs);
    #1;
    check(req, int'(victimWay), modelVictim(qs));
    check("R8", int'(victim1), 0);
    @(posedge clk);
    if (clr) modelClear();
    else if (uv) modelUpdate(us, uw);
    @(negedge clk);
  endtask

  task automatic queryAll(string req);
    for (int s = 0; s < NS; s++) step(1'b0, 1'b0, 0, 0, s, req);
  endtask

  initial begin
    #(HALF * 2.0 * 150000.0);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0123;
    void'($urandom(seed));
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state, every set gives way 0
    queryAll("R1");

    // R2/R4: way 0 in set 3 -> root 1, node1 1 -> victim way 2
    step(1'b0, 1'b1, 3, 0, 3, "R6");
    check("R2", int'(victimWay), 2);
    // R3: way 3 in set 3 rewrites root and node2 only; node1 stays 1
    step(1'b0, 1'b1, 3, 3, 3, "R6");
    check("R3", int'(victimWay), 1);
    // R5: other sets still at way 0
    step(1'b0, 1'b0, 0, 0, 4, "R5");
    check("R5", int'(victimWay), 0);
    // R9: each way touched then queried
    for (int w = 0; w < NW; w++) begin
      step(1'b0, 1'b1, 7, w, 7, "R6");
      checks++;
      if (int'(victimWay) == w) begin
        errors++;
        $display("FAIL R9: got %0d expected not %0d", victimWay, w);
      end
    end
    // R7: clear together with an update, clear wins
    step(1'b1, 1'b1, 7, 1, 7, "R7");
    queryAll("R7");

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      bit clr = ($urandom_range(63) == 0);
      bit uv  = ($urandom_range(9) < 7);
      int us  = int'($urandom_range(NS - 1));
      int uw  = int'($urandom_range(NW - 1));
      int qs  = $urandom_range(1) ? us : int'($urandom_range(NS - 1));
      step(clr, uv, us, uw, qs, "R4");
    end

    // R1: reset again clears everything
    rstN = 1'b0;
    @(posedge clk);
    modelClear();
    @(negedge clk);
    rstN = 1'b1;
    queryAll("R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule